// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations in a small, fully associative array. Each slot holds a virtual page tag, a physical page number, the address-space identifier of its owner and a flag that marks the page as shared by every address space. It also holds a read-permission mask and a write-permission mask, with one bit per privilege mode, and two trap bits that ask for a fault on the next read or write. A translation request gives a virtual page and the current address-space identifier. One clock edge later the block returns whether a slot matched, the slot number and the stored fields.

New translations are written into the slot named by a rotating victim pointer. Whatever that slot held is overwritten. Three invalidation commands keep the array consistent with the page tables. The first empties the array. The second drops every private translation and keeps the shared ones. The third drops the translations of one page as seen from one address space. A slot-inspect command shows the slot under the victim pointer on the result bus, and it can optionally step the pointer. Page walks, fault generation and counters live outside.

Top module: `tlb_assoc`

## Requirements
- R1: A lookup matches slot i only if slot i is valid, its tag equals the requested virtual page, and either its shared flag is 1 or its stored identifier equals the requested identifier.
- R2: When several slots match, the result reports the lowest-numbered one and raises the multi-match flag. With exactly one match the flag is 0.
- R3: The result of a lookup or slot-inspect appears on the result bus after the next rising clock edge, with the valid strobe high. The lookup sees the array as it was before that edge, so an insert in the same cycle is not visible to it.
- R4: On a lookup miss, the hit flag is 0, the reported slot number is 0 and every entry field on the result bus is 0.
- R5: Insert writes the supplied page, identifier, shared flag, masks and trap bits into the slot under the victim pointer, overwriting it, and marks it valid.
- R6: Each insert advances the victim pointer by one. The pointer wraps from ENTRIES-1 to 0.
- R7: Flush-all marks every slot invalid and returns the victim pointer to 0.
- R8: Flush-private invalidates every slot whose shared flag is 0, leaves shared slots valid, and leaves the pointer unchanged.
- R9: Flush-page invalidates exactly the slots that satisfy the R1 rule for the supplied page and identifier. All other slots keep their state.
- R10: Slot-inspect reports the victim pointer as the slot number, that slot's valid bit as the hit flag and its fields (zero when invalid), with multi-match 0. The pointer steps by one (wrapping) only when the advance input is also 1. Slot-inspect takes the result bus over a lookup issued in the same cycle.
- R11: Only one state-changing command acts per cycle. The order is flush-all, then flush-private, then flush-page, then insert, then inspect-advance, and every lower command in that cycle is ignored.
- R12: Reset, asserted low, empties the array, sets the pointer to 0 and clears the result bus, with the valid strobe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vld | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_asn | input | ASN_W | Lookup address-space identifier |
| ins_vld | input | 1 | Insert command |
| ins_vpn | input | VPN_W | Insert virtual page |
| ins_ppn | input | PPN_W | Insert physical page |
| ins_asn | input | ASN_W | Insert address-space identifier |
| ins_glob | input | 1 | Insert shared flag |
| ins_rmask | input | MODE_N | Insert read-enable mask per mode |
| ins_wmask | input | MODE_N | Insert write-enable mask per mode |
| ins_fonr | input | 1 | Insert trap-on-read bit |
| ins_fonw | input | 1 | Insert trap-on-write bit |
| fl_all | input | 1 | Flush-all command |
| fl_priv | input | 1 | Flush-private command |
| fl_page | input | 1 | Flush-page command |
| fl_vpn | input | VPN_W | Flush-page virtual page |
| fl_asn | input | ASN_W | Flush-page identifier |
| ix_rd | input | 1 | Slot-inspect command |
| ix_adv | input | 1 | Step the pointer with slot-inspect |
| res_vld | output | 1 | Result strobe |
| res_hit | output | 1 | Match found / inspected slot valid |
| res_multi | output | 1 | More than one slot matched |
| res_idx | output | IDX_W | Slot number |
| res_tag | output | VPN_W | Slot tag |
| res_ppn | output | PPN_W | Slot physical page |
| res_asn | output | ASN_W | Slot identifier |
| res_glob | output | 1 | Slot shared flag |
| res_rmask | output | MODE_N | Slot read-enable mask |
| res_wmask | output | MODE_N | Slot write-enable mask |
| res_fonr | output | 1 | Slot trap-on-read bit |
| res_fonw | output | 1 | Slot trap-on-write bit |

## Verification
The match rule is probed with one page held by two private identifiers and one shared slot. The bench asks with the owning identifier, with a foreign identifier, with any identifier against the shared slot, and with an absent page, which separates a tag-only compare from a correct identifier-or-shared compare. Adding a private alias of a shared page then checks that the lowest slot wins and that the multi-match flag is raised only when two slots really match. Further probes combine commands in one cycle: insert with lookup, insert with a flush, and inspect with lookup. Wrapping inserts and a mix of shared and private slots before each flush show which slots every flush must spare.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned VPN_W  = 12;
  parameter int unsigned PPN_W  = 10;
  parameter int unsigned ASN_W  = 4;
  parameter int unsigned MODE_N = 4;

  typedef struct packed {
    logic [VPN_W-1:0]  tag;
    logic [PPN_W-1:0]  ppn;
    logic [ASN_W-1:0]  asn;
    logic              glob;
    logic [MODE_N-1:0] rmask;
    logic [MODE_N-1:0] wmask;
    logic              fonr;
    logic              fonw;
  } entry_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_FLUSH_ALL,
    OP_FLUSH_PRIV,
    OP_FLUSH_PAGE,
    OP_INSERT,
    OP_IDX_ADV
  } op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; #(
  parameter int unsigned ENTRIES = 8
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  entry_t             ents [ENTRIES],
  input  logic [VPN_W-1:0]   vpn,
  input  logic [ASN_W-1:0]   asn,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_vec[g] && (ents[g].tag == vpn) &&
                        (ents[g].glob || (ents[g].asn == asn));
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               any,
  output logic               multi,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any   = 1'b0;
    multi = 1'b0;
    idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        if (any) begin
          multi = 1'b1;
        end else begin
          any = 1'b1;
          idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  assign ptr_en = clear | step;

  always_comb begin
    if (clear) begin
      ptr_d = '0;
    end else if (ptr_q == LAST) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc import tlb_pkg::*; #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_vld,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  input  logic              ins_vld,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [ASN_W-1:0]  ins_asn,
  input  logic              ins_glob,
  input  logic [MODE_N-1:0] ins_rmask,
  input  logic [MODE_N-1:0] ins_wmask,
  input  logic              ins_fonr,
  input  logic              ins_fonw,
  input  logic              fl_all,
  input  logic              fl_priv,
  input  logic              fl_page,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASN_W-1:0]  fl_asn,
  input  logic              ix_rd,
  input  logic              ix_adv,
  output logic              res_vld,
  output logic              res_hit,
  output logic              res_multi,
  output logic [IDX_W-1:0]  res_idx,
  output logic [VPN_W-1:0]  res_tag,
  output logic [PPN_W-1:0]  res_ppn,
  output logic [ASN_W-1:0]  res_asn,
  output logic              res_glob,
  output logic [MODE_N-1:0] res_rmask,
  output logic [MODE_N-1:0] res_wmask,
  output logic              res_fonr,
  output logic              res_fonw
);
  typedef struct packed {
    logic             hit;
    logic             multi;
    logic [IDX_W-1:0] idx;
    entry_t           ent;
  } result_t;

  op_e                op;
  logic [ENTRIES-1:0] valid_q, valid_d, glob_vec;
  logic [ENTRIES-1:0] lk_match, fl_match;
  entry_t             ent_q [ENTRIES];
  entry_t             new_ent;
  logic [IDX_W-1:0]   ptr_q;
  logic               lk_any, lk_multi;
  logic [IDX_W-1:0]   lk_idx;
  logic               res_en, res_vld_q;
  result_t            res_q, res_d;

  // one state-changing command per cycle, fixed priority
  always_comb begin
    if (fl_all)                op = OP_FLUSH_ALL;
    else if (fl_priv)          op = OP_FLUSH_PRIV;
    else if (fl_page)          op = OP_FLUSH_PAGE;
    else if (ins_vld)          op = OP_INSERT;
    else if (ix_rd && ix_adv)  op = OP_IDX_ADV;
    else                       op = OP_NONE;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_glob
    assign glob_vec[g] = ent_q[g].glob;
  end

  tlb_match #(.ENTRIES(ENTRIES)) i_lk_match (
    .valid_vec(valid_q), .ents(ent_q), .vpn(lk_vpn), .asn(lk_asn),
    .hit_vec(lk_match)
  );

  tlb_match #(.ENTRIES(ENTRIES)) i_fl_match (
    .valid_vec(valid_q), .ents(ent_q), .vpn(fl_vpn), .asn(fl_asn),
    .hit_vec(fl_match)
  );

  tlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_pick (
    .hit_vec(lk_match), .any(lk_any), .multi(lk_multi), .idx(lk_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
    .clk(clk), .rst_n(rst_n),
    .clear(op == OP_FLUSH_ALL),
    .step((op == OP_INSERT) || (op == OP_IDX_ADV)),
    .ptr(ptr_q)
  );

  assign new_ent = '{tag: ins_vpn, ppn: ins_ppn, asn: ins_asn, glob: ins_glob,
                     rmask: ins_rmask, wmask: ins_wmask,
                     fonr: ins_fonr, fonw: ins_fonw};

  always_comb begin
    valid_d = valid_q;
    case (op)
      OP_FLUSH_ALL:  valid_d = '0;
      OP_FLUSH_PRIV: valid_d = valid_q & glob_vec;
      OP_FLUSH_PAGE: valid_d = valid_q & ~fl_match;
      OP_INSERT:     valid_d[ptr_q] = 1'b1;
      default:       valid_d = valid_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // payload storage carries no reset: guarded by valid_q
  always_ff @(posedge clk) begin
    if (op == OP_INSERT) begin
      ent_q[ptr_q] <= new_ent;
    end
  end

  assign res_en = lk_vld | ix_rd;

  always_comb begin
    res_d = '0;
    if (ix_rd) begin
      res_d.idx = ptr_q;
      res_d.hit = valid_q[ptr_q];
      if (valid_q[ptr_q]) res_d.ent = ent_q[ptr_q];
    end else if (lk_any) begin
      res_d.hit   = 1'b1;
      res_d.multi = lk_multi;
      res_d.idx   = lk_idx;
      res_d.ent   = ent_q[lk_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_q <= 1'b0;
    end else begin
      res_vld_q <= res_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign res_vld   = res_vld_q;
  assign res_hit   = res_q.hit;
  assign res_multi = res_q.multi;
  assign res_idx   = res_q.idx;
  assign res_tag   = res_q.ent.tag;
  assign res_ppn   = res_q.ent.ppn;
  assign res_asn   = res_q.ent.asn;
  assign res_glob  = res_q.ent.glob;
  assign res_rmask = res_q.ent.rmask;
  assign res_wmask = res_q.ent.wmask;
  assign res_fonr  = res_q.ent.fonr;
  assign res_fonw  = res_q.ent.fonw;
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk import tlb_pkg::*; #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input op_e                op,
  input logic [IDX_W-1:0]   ptr_q,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] glob_vec,
  input logic               lk_vld,
  input logic               ix_rd,
  input logic               res_vld,
  input logic               res_hit,
  input logic               res_multi,
  input logic [IDX_W-1:0]   res_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INSERT) |=>
      ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

  p_insert_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INSERT) |=> (((valid_q >> $past(ptr_q)) & 1) != 0));

  p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLUSH_ALL) |=> (ptr_q == '0) && (valid_q == '0));

  p_flush_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLUSH_PRIV) |=> ((valid_q & ~glob_vec) == '0) && $stable(ptr_q));

  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> $stable(ptr_q));

  p_multi_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_multi |-> res_hit);

  p_result_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld || ix_rd) |=> res_vld);

  p_hit_was_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit && !$past(ix_rd)) |->
      ((($past(valid_q) >> res_idx) & 1) != 0));
endmodule

bind tlb_assoc tlb_assoc_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .ptr_q(ptr_q), .valid_q(valid_q),
  .glob_vec(glob_vec), .lk_vld(lk_vld), .ix_rd(ix_rd), .res_vld(res_vld),
  .res_hit(res_hit), .res_multi(res_multi), .res_idx(res_idx)
);

// File: tb/test_tlb_assoc.sv
module test_tlb_assoc;
  import tlb_pkg::*;
  localparam int unsigned ENTRIES = 8;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst_n;
  logic lk_vld, ins_vld, ins_glob, ins_fonr, ins_fonw;
  logic fl_all, fl_priv, fl_page, ix_rd, ix_adv;
  logic [VPN_W-1:0] lk_vpn, ins_vpn, fl_vpn;
  logic [ASN_W-1:0] lk_asn, ins_asn, fl_asn;
  logic [PPN_W-1:0] ins_ppn;
  logic [MODE_N-1:0] ins_rmask, ins_wmask;
  logic res_vld, res_hit, res_multi, res_glob, res_fonr, res_fonw;
  logic [IDX_W-1:0] res_idx;
  logic [VPN_W-1:0] res_tag;
  logic [PPN_W-1:0] res_ppn;
  logic [ASN_W-1:0] res_asn;
  logic [MODE_N-1:0] res_rmask, res_wmask;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tlb_assoc #(.ENTRIES(ENTRIES)) i_tlb_assoc (.*);

  typedef struct packed {
    logic             ins;
    logic [11:0]      vpn;
    logic [3:0]       asn;
    logic             glob;
    logic [9:0]       ppn;
    logic             e_hit;
    logic             e_multi;
    logic [2:0]       e_idx;
    logic [9:0]       e_ppn;
  } vec_t;

  localparam vec_t TV [11] = '{
    '{1'b1, 12'h100, 4'd1, 1'b0, 10'h011, 1'b0, 1'b0, 3'd0, 10'h000},
    '{1'b1, 12'h200, 4'd2, 1'b1, 10'h022, 1'b0, 1'b0, 3'd0, 10'h000},
    '{1'b1, 12'h100, 4'd3, 1'b0, 10'h033, 1'b0, 1'b0, 3'd0, 10'h000},
    '{1'b0, 12'h100, 4'd1, 1'b0, 10'h000, 1'b1, 1'b0, 3'd0, 10'h011},
    '{1'b0, 12'h100, 4'd3, 1'b0, 10'h000, 1'b1, 1'b0, 3'd2, 10'h033},
    '{1'b0, 12'h100, 4'd2, 1'b0, 10'h000, 1'b0, 1'b0, 3'd0, 10'h000},
    '{1'b0, 12'h200, 4'd7, 1'b0, 10'h000, 1'b1, 1'b0, 3'd1, 10'h022},
    '{1'b0, 12'h300, 4'd1, 1'b0, 10'h000, 1'b0, 1'b0, 3'd0, 10'h000},
    '{1'b1, 12'h200, 4'd5, 1'b0, 10'h044, 1'b0, 1'b0, 3'd0, 10'h000},
    '{1'b0, 12'h200, 4'd5, 1'b0, 10'h000, 1'b1, 1'b1, 3'd1, 10'h022},
    '{1'b0, 12'h200, 4'd6, 1'b0, 10'h000, 1'b1, 1'b0, 3'd1, 10'h022}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_vld = 0; ins_vld = 0; fl_all = 0; fl_priv = 0; fl_page = 0;
    ix_rd = 0; ix_adv = 0;
  endtask

  task automatic set_ins(input logic [11:0] vpn, input logic [3:0] asn,
                         input logic glob, input logic [9:0] ppn);
    ins_vld = 1; ins_vpn = vpn; ins_asn = asn; ins_glob = glob; ins_ppn = ppn;
    ins_rmask = ppn[3:0]; ins_wmask = ~ppn[3:0];
    ins_fonr = ppn[0]; ins_fonw = ppn[1];
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic chk_res(input string req, input logic hit, input logic multi,
                         input logic [IDX_W-1:0] idx, input logic [9:0] ppn);
    chk(res_vld == 1'b1, req, "strobe", 32'(res_vld), 32'd1);
    chk(res_hit == hit, req, "hit", 32'(res_hit), 32'(hit));
    chk(res_multi == multi, req, "multi", 32'(res_multi), 32'(multi));
    chk(res_idx == idx, req, "slot", 32'(res_idx), 32'(idx));
    chk(res_ppn == ppn, req, "ppn", 32'(res_ppn), 32'(ppn));
  endtask

  task automatic lookup(input logic [11:0] vpn, input logic [3:0] asn,
                        input string req, input logic hit, input logic multi,
                        input logic [IDX_W-1:0] idx, input logic [9:0] ppn);
    lk_vld = 1; lk_vpn = vpn; lk_asn = asn;
    step();
    chk_res(req, hit, multi, idx, ppn);
  endtask

  task automatic inspect(input logic adv, input string req, input logic hit,
                         input logic [IDX_W-1:0] idx, input logic [9:0] ppn);
    ix_rd = 1; ix_adv = adv;
    step();
    chk_res(req, hit, 1'b0, idx, ppn);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    lk_vpn = '0; lk_asn = '0; fl_vpn = '0; fl_asn = '0;
    ins_vpn = '0; ins_asn = '0; ins_glob = 0; ins_ppn = '0;
    ins_rmask = '0; ins_wmask = '0; ins_fonr = 0; ins_fonw = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(res_vld == 0, "R12", "strobe in reset", 32'(res_vld), 32'd0);
    chk(res_hit == 0, "R12", "hit in reset", 32'(res_hit), 32'd0);
    rst_n = 1;
    @(negedge clk);
    inspect(1'b0, "R12 pointer after reset", 1'b0, 3'd0, 10'h000);

    // table: R1 R2 R4 R5 rule, lowest slot, miss zeros, stored fields
    foreach (TV[i]) begin
      if (TV[i].ins) begin
        set_ins(TV[i].vpn, TV[i].asn, TV[i].glob, TV[i].ppn);
        step();
      end else begin
        lookup(TV[i].vpn, TV[i].asn, "R1/R2/R4/R5 table", TV[i].e_hit,
               TV[i].e_multi, TV[i].e_idx, TV[i].e_ppn);
        chk(res_rmask == TV[i].e_ppn[3:0], "R5 table rmask", "rmask",
            32'(res_rmask), 32'(TV[i].e_ppn[3:0]));
        chk(res_fonr == (TV[i].e_hit & TV[i].e_ppn[0]), "R5 table fonr", "fonr",
            32'(res_fonr), 32'(TV[i].e_hit & TV[i].e_ppn[0]));
      end
    end

    // R3: insert in the same cycle as a lookup is not yet visible
    set_ins(12'h500, 4'd1, 1'b0, 10'h055);
    lk_vld = 1; lk_vpn = 12'h500; lk_asn = 4'd1;
    step();
    chk_res("R3 same-cycle insert", 1'b0, 1'b0, 3'd0, 10'h000);
    lookup(12'h500, 4'd1, "R3 next cycle", 1'b1, 1'b0, 3'd4, 10'h055);

    // R10: inspect without and with advance, priority over lookup
    inspect(1'b0, "R10 no advance", 1'b0, 3'd5, 10'h000);
    inspect(1'b1, "R10 advance", 1'b0, 3'd5, 10'h000);
    inspect(1'b0, "R10 after advance", 1'b0, 3'd6, 10'h000);
    lk_vld = 1; lk_vpn = 12'h100; lk_asn = 4'd3;
    inspect(1'b0, "R10 bus priority", 1'b0, 3'd6, 10'h000);

    // R6: wrap of the victim pointer, overwrite of slot 0
    set_ins(12'h600, 4'd1, 1'b0, 10'h066); step();
    set_ins(12'h700, 4'd1, 1'b0, 10'h077); step();
    set_ins(12'h800, 4'd1, 1'b0, 10'h088); step();
    inspect(1'b0, "R6 wrapped pointer", 1'b1, 3'd1, 10'h022);
    chk(res_tag == 12'h200, "R10 inspect tag", "tag", 32'(res_tag), 32'h200);
    lookup(12'h100, 4'd1, "R5 overwritten slot", 1'b0, 1'b0, 3'd0, 10'h000);
    lookup(12'h800, 4'd1, "R6 wrapped insert", 1'b1, 1'b0, 3'd0, 10'h088);

    // R11: flush-page wins over insert in the same cycle
    set_ins(12'h900, 4'd1, 1'b0, 10'h099);
    fl_page = 1; fl_vpn = 12'h800; fl_asn = 4'd1;
    step();
    lookup(12'h900, 4'd1, "R11 insert dropped", 1'b0, 1'b0, 3'd0, 10'h000);
    lookup(12'h800, 4'd1, "R9 page removed", 1'b0, 1'b0, 3'd0, 10'h000);
    inspect(1'b0, "R11 pointer held", 1'b1, 3'd1, 10'h022);

    // R9: shared slot removed, other identifier kept
    fl_page = 1; fl_vpn = 12'h200; fl_asn = 4'd9;
    step();
    lookup(12'h200, 4'd5, "R9 private alias kept", 1'b1, 1'b0, 3'd3, 10'h044);
    lookup(12'h100, 4'd3, "R9 other page kept", 1'b1, 1'b0, 3'd2, 10'h033);

    // R8: flush-private spares shared slots
    set_ins(12'hA00, 4'd0, 1'b1, 10'h0AA); step();
    fl_priv = 1; step();
    lookup(12'hA00, 4'd7, "R8 shared kept", 1'b1, 1'b0, 3'd1, 10'h0AA);
    lookup(12'h200, 4'd5, "R8 private gone", 1'b0, 1'b0, 3'd0, 10'h000);
    lookup(12'h500, 4'd1, "R8 private gone", 1'b0, 1'b0, 3'd0, 10'h000);
    inspect(1'b0, "R8 pointer kept", 1'b0, 3'd2, 10'h000);

    // R7 with R11: flush-all beats insert
    set_ins(12'hC00, 4'd2, 1'b1, 10'h0CC);
    fl_all = 1; step();
    lookup(12'hA00, 4'd7, "R7 shared gone", 1'b0, 1'b0, 3'd0, 10'h000);
    lookup(12'hC00, 4'd2, "R7 insert dropped", 1'b0, 1'b0, 3'd0, 10'h000);
    inspect(1'b0, "R7 pointer zero", 1'b0, 3'd0, 10'h000);

    // R12: reset in mid-run
    set_ins(12'hB00, 4'd0, 1'b0, 10'h0BB); step();
    set_ins(12'hB10, 4'd0, 1'b0, 10'h0B1); step();
    rst_n = 0;
    @(negedge clk);
    chk(res_vld == 0, "R12", "strobe after reset", 32'(res_vld), 32'd0);
    rst_n = 1;
    @(negedge clk);
    inspect(1'b0, "R12 pointer cleared", 1'b0, 3'd0, 10'h000);
    lookup(12'hB00, 4'd0, "R12 array cleared", 1'b0, 1'b0, 3'd0, 10'h000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule